// File: doc/BRIEF.md
# Configurable Logic Slice Tile

This block is a single tile of a small programmable fabric laid out as a grid. Two lookup tables of three inputs each share one set of input selections and yield two results. Each result can leave the tile as it is computed, or as the copy a clocked register took at the previous edge. A configuration bit makes that choice for each result separately. The results can drive chosen lines of four 2-lane buses, one bus on each edge of the tile.

Each bus lane on the top edge pairs with the matching lane on the bottom edge. Each lane on the left edge pairs with the matching lane on the right edge. A configuration switch either joins a pair into one net or splits it into two separate segments. Joining pairs lets tiles be set side by side and cascaded. All configuration bits enter through one serial chain. The chain passes its overflow to the next tile, and a load strobe copies the shifted image into the active settings all at once.

A bus line has no inout pin. It is modelled as an incoming value, an incoming "driven" flag, an outgoing value and an outgoing drive enable. Wiring the outgoing pair of one tile to the incoming pair of its neighbour builds the grid.

Top module: `cfg_slice_tile`

## Requirements
- R1: While reset is asserted, and after it until the first load, every drive enable is 0, every bus output is 0 and the chain output is 0.
- R2: With the shift strobe high, each clock moves the chain one place toward the chain output and enters the serial input at the far end. The chain output shows the bit that entered 47 shifts earlier, and it holds while the strobe is low. After 47 shifts, the first bit sent sits at image bit 0. The image fields, from bit 0 upward, are as follows. Table A is bits 0-7. Table B is bits 8-15. Input selects 0, 1 and 2 are 3 bits each at bits 16, 19 and 22. The register-select bits for A and B are bits 25 and 26. Bus line n has its drive enable at bit 27+2n and its source (0 = A, 1 = B) at bit 28+2n. The switch bits are bits 43-46.
- R3: The active configuration changes only on a clock with the load strobe high. Shifting without a load leaves the tile's behaviour unchanged.
- R4: Each table output is the table bit indexed by {input2, input1, input0}.
- R5: An input select code picks the line that feeds that input: up0=0, up1=1, down0=2, down1=3, left0=4, left1=5, right0=6, right1=7. The same numbers are the bus line numbers n.
- R6: With its register-select bit at 1, a result is the table output captured at the previous clock edge. With the bit at 0, the result follows the table output in the same cycle.
- R7: A bus line is driven by the tile only when its enable bit is 1, and it then carries the result its source bit names.
- R8: When switch k is open (bit 43+k = 0), the two sides of pair k are independent. A value driven into one side never appears on the other side. Pairs 0 and 1 are up/down lanes 0 and 1. Pairs 2 and 3 are left/right lanes 0 and 1.
- R9: When a switch is closed and the tile does not drive the pair, an externally driven side is passed to the other side with its drive enable set. When the tile drives either side of a closed pair, it drives that value on both sides.
- R10: An input that selects a line of a closed pair driven by a registered result reads that registered value. The tile can therefore hold a bit through feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift | input | 1 | Shift one configuration bit in |
| cfg_din | input | 1 | Serial configuration input |
| cfg_load | input | 1 | Copy the shifted image into the active configuration |
| cfg_dout | output | 1 | Serial configuration output toward the next tile |
| up_in | input | 2 | Values arriving on the top-edge lanes |
| up_vld | input | 2 | Top-edge lanes driven from outside |
| up_out | output | 2 | Values the tile puts on the top-edge lanes |
| up_drv | output | 2 | Top-edge drive enables |
| dn_in | input | 2 | Values arriving on the bottom-edge lanes |
| dn_vld | input | 2 | Bottom-edge lanes driven from outside |
| dn_out | output | 2 | Values the tile puts on the bottom-edge lanes |
| dn_drv | output | 2 | Bottom-edge drive enables |
| lf_in | input | 2 | Values arriving on the left-edge lanes |
| lf_vld | input | 2 | Left-edge lanes driven from outside |
| lf_out | output | 2 | Values the tile puts on the left-edge lanes |
| lf_drv | output | 2 | Left-edge drive enables |
| rt_in | input | 2 | Values arriving on the right-edge lanes |
| rt_vld | input | 2 | Right-edge lanes driven from outside |
| rt_out | output | 2 | Values the tile puts on the right-edge lanes |
| rt_drv | output | 2 | Right-edge drive enables |

## Verification
Combinational results and pass-through values are due in the same cycle as the input change. The bench therefore drives on the falling edge and samples one time step later. A registered result is due one rising edge after its inputs. The bench checks it at the next falling edge, before it applies the next vector, against a value its reference model carried over from the previous step. A new configuration takes effect from the edge that samples the load strobe. The chain output is compared after each shifting edge with the bit entered 47 shifts before.

// File: rtl/slice_pkg.sv
package slice_pkg;
   typedef enum int {
      SIDE_UP = 0,
      SIDE_DN = 1,
      SIDE_LF = 2,
      SIDE_RT = 3
   } side_e;

   localparam int NUM_SIDES = 4;

   function automatic int line_of(input side_e side, input int lane, input int lanes);
      return int'(side) * lanes + lane;
   endfunction

   function automatic int src_bits(input int n_lut);
      return (n_lut > 1) ? $clog2(n_lut) : 1;
   endfunction
endpackage

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain #(
   parameter int LEN = 47
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sh_en,
   input  logic           sh_din,
   input  logic           ld,
   output logic           sh_dout,
   output logic [LEN-1:0] active
);
   logic [LEN-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
      end else begin
         if (sh_en) shadow <= {sh_din, shadow[LEN-1:1]};
         if (ld)    active <= shadow;
      end
   end

   assign sh_dout = shadow[0];
endmodule

// File: rtl/slice_lut.sv
module slice_lut #(
   parameter int K = 3
) (
   input  logic [(1<<K)-1:0] table_bits,
   input  logic [K-1:0]      idx,
   output logic              y
);
   assign y = table_bits[idx];
endmodule

// File: rtl/slice_out_stage.sv
module slice_out_stage #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   input  logic [N-1:0] use_reg,
   output logic [N-1:0] q,
   output logic [N-1:0] y
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   for (genvar j = 0; j < N; j++) begin : g_pick
      assign y[j] = use_reg[j] ? q[j] : d[j];
   end
endmodule

// File: rtl/slice_bus_pair.sv
module slice_bus_pair (
   input  logic a_in,
   input  logic a_vld,
   input  logic b_in,
   input  logic b_vld,
   input  logic closed,
   input  logic en_a,
   input  logic en_b,
   input  logic val_a,
   input  logic val_b,
   input  logic rg_a,
   input  logic rg_b,
   input  logic qv_a,
   input  logic qv_b,
   output logic a_out,
   output logic a_drv,
   output logic b_out,
   output logic b_drv,
   output logic a_sense,
   output logic b_sense
);
   logic loc_en, loc_val, loc_reg, loc_q, ext_val;

   always_comb begin
      loc_en  = en_a | en_b;
      loc_val = en_a ? val_a : val_b;
      loc_reg = en_a ? rg_a : (en_b & rg_b);
      loc_q   = en_a ? qv_a : qv_b;
      ext_val = a_vld ? a_in : (b_vld ? b_in : 1'b0);
      if (closed) begin
         a_drv   = loc_en | b_vld;
         a_out   = loc_en ? loc_val : b_in;
         b_drv   = loc_en | a_vld;
         b_out   = loc_en ? loc_val : a_in;
         a_sense = loc_reg ? loc_q : ext_val;
         b_sense = a_sense;
      end else begin
         a_drv   = en_a;
         a_out   = en_a & val_a;
         b_drv   = en_b;
         b_out   = en_b & val_b;
         a_sense = (en_a & rg_a) ? qv_a : a_in;
         b_sense = (en_b & rg_b) ? qv_b : b_in;
      end
   end
endmodule

// File: rtl/cfg_slice_tile.sv
module cfg_slice_tile
   import slice_pkg::*;
#(
   parameter int LUT_K   = 3,
   parameter int NUM_LUT = 2,
   parameter int LANES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_shift,
   input  logic             cfg_din,
   input  logic             cfg_load,
   output logic             cfg_dout,
   input  logic [LANES-1:0] up_in,
   input  logic [LANES-1:0] up_vld,
   output logic [LANES-1:0] up_out,
   output logic [LANES-1:0] up_drv,
   input  logic [LANES-1:0] dn_in,
   input  logic [LANES-1:0] dn_vld,
   output logic [LANES-1:0] dn_out,
   output logic [LANES-1:0] dn_drv,
   input  logic [LANES-1:0] lf_in,
   input  logic [LANES-1:0] lf_vld,
   output logic [LANES-1:0] lf_out,
   output logic [LANES-1:0] lf_drv,
   input  logic [LANES-1:0] rt_in,
   input  logic [LANES-1:0] rt_vld,
   output logic [LANES-1:0] rt_out,
   output logic [LANES-1:0] rt_drv
);
   localparam int TBL_W    = 1 << LUT_K;
   localparam int NLINE    = NUM_SIDES * LANES;
   localparam int SEL_W    = $clog2(NLINE);
   localparam int SRC_W    = src_bits(NUM_LUT);
   localparam int OE_W     = 1 + SRC_W;
   localparam int NSW      = 2 * LANES;
   localparam int OFF_SEL  = NUM_LUT * TBL_W;
   localparam int OFF_RSEL = OFF_SEL + LUT_K * SEL_W;
   localparam int OFF_OE   = OFF_RSEL + NUM_LUT;
   localparam int OFF_SW   = OFF_OE + NLINE * OE_W;
   localparam int CFG_LEN  = OFF_SW + NSW;

   if (LUT_K < 1 || LUT_K > 6) begin : g_bad_k
      $error("LUT_K must lie in 1..6");
   end
   if (NUM_LUT < 1 || NUM_LUT > 8) begin : g_bad_n
      $error("NUM_LUT must lie in 1..8");
   end
   if (LANES < 1 || LANES > 8) begin : g_bad_l
      $error("LANES must lie in 1..8");
   end

   logic [CFG_LEN-1:0] act_cfg;
   logic [NUM_LUT-1:0] lut_y, reg_q, out_y, rsel;
   logic [LUT_K-1:0]   lut_in;
   logic [NLINE-1:0]   line_in, line_vld, line_out, line_drv, line_sense;
   logic [NLINE-1:0]   line_en, line_val, line_rg, line_qv;

   slice_cfg_chain #(.LEN(CFG_LEN)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .sh_en  (cfg_shift),
      .sh_din (cfg_din),
      .ld     (cfg_load),
      .sh_dout(cfg_dout),
      .active (act_cfg)
   );

   assign line_in  = {rt_in, lf_in, dn_in, up_in};
   assign line_vld = {rt_vld, lf_vld, dn_vld, up_vld};

   localparam int UP0 = line_of(SIDE_UP, 0, LANES);
   localparam int DN0 = line_of(SIDE_DN, 0, LANES);
   localparam int LF0 = line_of(SIDE_LF, 0, LANES);
   localparam int RT0 = line_of(SIDE_RT, 0, LANES);

   assign up_out = line_out[UP0 +: LANES];
   assign up_drv = line_drv[UP0 +: LANES];
   assign dn_out = line_out[DN0 +: LANES];
   assign dn_drv = line_drv[DN0 +: LANES];
   assign lf_out = line_out[LF0 +: LANES];
   assign lf_drv = line_drv[LF0 +: LANES];
   assign rt_out = line_out[RT0 +: LANES];
   assign rt_drv = line_drv[RT0 +: LANES];

   // input selection: each table input reads the sensed value of one line
   for (genvar i = 0; i < LUT_K; i++) begin : g_insel
      logic [SEL_W-1:0] code;
      assign code      = act_cfg[OFF_SEL + i*SEL_W +: SEL_W];
      assign lut_in[i] = (int'(code) < NLINE) ? line_sense[code] : 1'b0;
   end

   for (genvar j = 0; j < NUM_LUT; j++) begin : g_lut
      slice_lut #(.K(LUT_K)) u_lut (
         .table_bits(act_cfg[j*TBL_W +: TBL_W]),
         .idx       (lut_in),
         .y         (lut_y[j])
      );
   end

   assign rsel = act_cfg[OFF_RSEL +: NUM_LUT];

   slice_out_stage #(.N(NUM_LUT)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (lut_y),
      .use_reg(rsel),
      .q      (reg_q),
      .y      (out_y)
   );

   // per-line drive source decode
   for (genvar n = 0; n < NLINE; n++) begin : g_line
      logic [SRC_W-1:0] src;
      logic             src_ok;
      assign src         = act_cfg[OFF_OE + n*OE_W + 1 +: SRC_W];
      assign src_ok      = int'(src) < NUM_LUT;
      assign line_en[n]  = act_cfg[OFF_OE + n*OE_W];
      assign line_val[n] = src_ok ? out_y[src] : out_y[0];
      assign line_rg[n]  = src_ok ? rsel[src]  : rsel[0];
      assign line_qv[n]  = src_ok ? reg_q[src] : reg_q[0];
   end

   // switch pairs: k < LANES joins up/down lane k, else left/right lane k-LANES
   for (genvar k = 0; k < NSW; k++) begin : g_pair
      localparam int IA = (k < LANES) ? k : (2*LANES + k - LANES);
      localparam int IB = IA + LANES;
      slice_bus_pair u_pair (
         .a_in   (line_in[IA]),
         .a_vld  (line_vld[IA]),
         .b_in   (line_in[IB]),
         .b_vld  (line_vld[IB]),
         .closed (act_cfg[OFF_SW + k]),
         .en_a   (line_en[IA]),
         .en_b   (line_en[IB]),
         .val_a  (line_val[IA]),
         .val_b  (line_val[IB]),
         .rg_a   (line_rg[IA]),
         .rg_b   (line_rg[IB]),
         .qv_a   (line_qv[IA]),
         .qv_b   (line_qv[IB]),
         .a_out  (line_out[IA]),
         .a_drv  (line_drv[IA]),
         .b_out  (line_out[IB]),
         .b_drv  (line_drv[IB]),
         .a_sense(line_sense[IA]),
         .b_sense(line_sense[IB])
      );
   end
endmodule

// File: rtl/cfg_slice_tile_chk.sv
module cfg_slice_tile_chk
   import slice_pkg::*;
#(
   parameter int LUT_K   = 3,
   parameter int NUM_LUT = 2,
   parameter int LANES   = 2
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                cfg_shift,
   input logic                                cfg_load,
   input logic                                cfg_dout,
   input logic [NUM_LUT*(1<<LUT_K) + LUT_K*$clog2(4*LANES) + NUM_LUT
                + 4*LANES*(1+src_bits(NUM_LUT)) + 2*LANES - 1:0] act_cfg,
   input logic [NUM_LUT-1:0]                  lut_y,
   input logic [NUM_LUT-1:0]                  reg_q,
   input logic [4*LANES-1:0]                  line_in,
   input logic [4*LANES-1:0]                  line_vld,
   input logic [4*LANES-1:0]                  line_out,
   input logic [4*LANES-1:0]                  line_drv
);
   localparam int NLINE  = 4 * LANES;
   localparam int OE_W   = 1 + src_bits(NUM_LUT);
   localparam int OFF_OE = NUM_LUT*(1<<LUT_K) + LUT_K*$clog2(NLINE) + NUM_LUT;
   localparam int OFF_SW = OFF_OE + NLINE*OE_W;

   a_r2_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_shift |=> $stable(cfg_dout));

   a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(act_cfg));

   a_r6_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (reg_q == $past(lut_y)));

   for (genvar k = 0; k < 2*LANES; k++) begin : g_pair_chk
      localparam int IA = (k < LANES) ? k : (2*LANES + k - LANES);
      localparam int IB = IA + LANES;

      a_r8_open_isolation: assert property (@(posedge clk) disable iff (!rst_n)
         (!act_cfg[OFF_SW+k] && !act_cfg[OFF_OE+IA*OE_W]) |-> !line_drv[IA]);

      a_r9_closed_pass: assert property (@(posedge clk) disable iff (!rst_n)
         (act_cfg[OFF_SW+k] && !act_cfg[OFF_OE+IA*OE_W] && !act_cfg[OFF_OE+IB*OE_W]
          && line_vld[IB]) |-> (line_drv[IA] && line_out[IA] == line_in[IB]));
   end

   for (genvar n = 0; n < NLINE; n++) begin : g_line_chk
      a_r7_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
         act_cfg[OFF_OE+n*OE_W] |-> line_drv[n]);
   end
endmodule

bind cfg_slice_tile cfg_slice_tile_chk #(
   .LUT_K  (LUT_K),
   .NUM_LUT(NUM_LUT),
   .LANES  (LANES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_shift(cfg_shift),
   .cfg_load (cfg_load),
   .cfg_dout (cfg_dout),
   .act_cfg  (act_cfg),
   .lut_y    (lut_y),
   .reg_q    (reg_q),
   .line_in  (line_in),
   .line_vld (line_vld),
   .line_out (line_out),
   .line_drv (line_drv)
);

// File: tb/tb_cfg_slice_tile.sv
module tb_cfg_slice_tile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
   int   n_chk = 0, n_err = 0;

   always #5 clk = ~clk;

   logic [1:0] w_up_i = '0, w_up_v = '0, w_dn_i = '0, w_dn_v = '0, w_lf_i = '0, w_lf_v = '0;
   logic [1:0] e_up_i = '0, e_up_v = '0, e_dn_i = '0, e_dn_v = '0, e_rt_i = '0, e_rt_v = '0;
   logic [1:0] w_up_o, w_up_d, w_dn_o, w_dn_d, w_lf_o, w_lf_d, w_rt_o, w_rt_d;
   logic [1:0] e_up_o, e_up_d, e_dn_o, e_dn_d, e_lf_o, e_lf_d, e_rt_o, e_rt_d;
   logic       w_dout, e_dout;

   cfg_slice_tile dut (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
      .cfg_load(cfg_load), .cfg_dout(w_dout),
      .up_in(w_up_i), .up_vld(w_up_v), .up_out(w_up_o), .up_drv(w_up_d),
      .dn_in(w_dn_i), .dn_vld(w_dn_v), .dn_out(w_dn_o), .dn_drv(w_dn_d),
      .lf_in(w_lf_i), .lf_vld(w_lf_v), .lf_out(w_lf_o), .lf_drv(w_lf_d),
      .rt_in(e_lf_o), .rt_vld(e_lf_d), .rt_out(w_rt_o), .rt_drv(w_rt_d)
   );

   cfg_slice_tile dut_e (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(w_dout),
      .cfg_load(cfg_load), .cfg_dout(e_dout),
      .up_in(e_up_i), .up_vld(e_up_v), .up_out(e_up_o), .up_drv(e_up_d),
      .dn_in(e_dn_i), .dn_vld(e_dn_v), .dn_out(e_dn_o), .dn_drv(e_dn_d),
      .lf_in(w_rt_o), .lf_vld(w_rt_d), .lf_out(e_lf_o), .lf_drv(e_lf_d),
      .rt_in(e_rt_i), .rt_vld(e_rt_v), .rt_out(e_rt_o), .rt_drv(e_rt_d)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // builds a 47-bit image from the field layout stated in R2
   function automatic logic [46:0] mk_cfg(
      input logic [7:0] ta, input logic [7:0] tb,
      input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2,
      input logic [1:0] rs, input logic [7:0] en, input logic [7:0] src,
      input logic [3:0] sw);
      logic [46:0] c;
      c = '0;
      c[7:0]   = ta;
      c[15:8]  = tb;
      c[18:16] = s0;
      c[21:19] = s1;
      c[24:22] = s2;
      c[26:25] = rs;
      for (int n = 0; n < 8; n++) begin
         c[27+2*n] = en[n];
         c[28+2*n] = src[n];
      end
      c[46:43] = sw;
      return c;
   endfunction

   task automatic send(input logic [46:0] east, input logic [46:0] west, input bit do_load);
      logic [93:0] s;
      s = {west, east};
      for (int i = 0; i < 94; i++) begin
         @(negedge clk);
         cfg_shift = 1'b1;
         cfg_din   = s[i];
         @(posedge clk);
         #1;
         if (i + 1 >= 47) chk("R2 chain out", {7'd0, w_dout}, {7'd0, s[i+1-47]});
      end
      @(negedge clk);
      cfg_shift = 1'b0;
      cfg_load  = do_load;
      @(negedge clk);
      cfg_load  = 1'b0;
   endtask

   task automatic load_only();
      @(negedge clk);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   // adder reference model: sum registered (due one edge later), carry combinational
   task automatic run_adder(input int steps, input string tag);
      logic prev_sum;
      bit   have_prev;
      have_prev = 0;
      prev_sum  = 1'b0;
      for (int i = 0; i < steps; i++) begin
         logic a, b, c, s, co;
         @(negedge clk);
         if (have_prev) chk({tag, " R6 registered sum"}, {7'd0, e_rt_o[0]}, {7'd0, prev_sum});
         a = i[0]; b = i[1]; c = i[2];
         w_lf_i[0] = a;
         w_dn_i[1] = b;
         w_up_i[0] = c;
         w_up_v    = 2'b11;
         #1;
         s  = a ^ b ^ c;
         co = (a & b) | (a & c) | (b & c);
         chk({tag, " R4 R5 comb carry"}, {7'd0, e_rt_o[1]}, {7'd0, co});
         chk({tag, " R7 R9 east drive"}, {6'd0, e_rt_d}, 8'd3);
         chk({tag, " R8 west vertical open"}, {6'd0, w_dn_d}, 8'd0);
         prev_sum  = s;
         have_prev = 1;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [46:0] w_add, e_pass, e_store;
      bit          q_known;
      logic        exp_q;

      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset drives", {w_up_d, w_dn_d, w_lf_d, w_rt_d}, 8'd0);
      chk("R1 reset outs", {e_up_o, e_dn_o, e_lf_o, e_rt_o}, 8'd0);
      chk("R1 reset dout", {6'd0, w_dout, e_dout}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // west: A = sum (registered), B = carry (comb); in0=left0 (4), in1=down1 (3), in2=up0 (0)
      w_add  = mk_cfg(8'h96, 8'hE8, 3'd4, 3'd3, 3'd0, 2'b01, 8'hC0, 8'h80, 4'b0000);
      // east: only horizontal pairs closed, so it relays west's right lines
      e_pass = mk_cfg(8'h00, 8'h00, 3'd0, 3'd0, 3'd0, 2'b00, 8'h00, 8'h00, 4'b1100);

      send(e_pass, w_add, 0);
      #1;
      chk("R3 no load keeps idle", {e_rt_d, w_rt_d, e_up_d, w_up_d}, 8'd0);
      load_only();
      run_adder(10, "adder");

      // east storage: A = (in0|in1) & !in2, in0=left0, in1=up0 set, in2=up1 clear
      e_store = mk_cfg(8'h0E, 8'h00, 3'd4, 3'd0, 3'd1, 2'b01, 8'h40, 8'h00, 4'b0110);
      send(e_store, 47'd0, 0);
      run_adder(4, "R3 shifted not loaded");
      load_only();

      q_known = 0;
      exp_q   = 1'b0;
      e_up_v  = 2'b01;
      e_dn_v  = 2'b10;
      for (int i = 0; i < 12; i++) begin
         logic set_b, clr_b;
         @(negedge clk);
         if (q_known) begin
            chk("R10 held bit on right0", {7'd0, e_rt_o[0]}, {7'd0, exp_q});
            chk("R9 held bit on left0", {6'd0, e_lf_d[0], e_lf_o[0]}, {6'd0, 1'b1, exp_q});
         end
         clr_b = (i == 0) || (i == 9);
         set_b = (i == 4);
         e_up_i[0] = set_b;
         e_dn_i[1] = clr_b;
         #1;
         chk("R9 down1 passed to up1", {6'd0, e_up_d[1], e_up_o[1]}, {6'd0, 1'b1, clr_b});
         chk("R8 up0 isolated", {6'd0, e_dn_d[0], e_rt_d[1]}, 8'd0);
         exp_q   = clr_b ? 1'b0 : (set_b | exp_q);
         q_known = 1;
      end

      // open every switch: passing stops on all sides
      send(mk_cfg(8'h00, 8'h00, 3'd0, 3'd0, 3'd0, 2'b00, 8'h00, 8'h00, 4'b0000), 47'd0, 1);
      e_dn_i = 2'b11; e_dn_v = 2'b11; e_up_v = 2'b11; e_rt_v = 2'b11; e_rt_i = 2'b11;
      #1;
      chk("R8 all open east", {e_up_d, e_dn_d, e_lf_d, e_rt_d}, 8'd0);
      chk("R7 no enable west", {w_up_d, w_dn_d, w_lf_d, w_rt_d}, 8'd0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule